// File: doc/BRIEF.md
# Pause Frame Transmit Generator

This block builds a flow-control pause frame on request and sends it to the transmit path as a stream of bytes. Either of two request strobes asks for a frame. The request is kept only while the transmitter enable flag is high. The frame starts as soon as the normal data path reports that it is between frames. Until then, and for the whole length of the generated frame, a hold output tells the normal path not to start a new frame.

The frame is 60 bytes long and carries no FCS; preamble and checksum are added further down the transmit path. The header has these fields in this order:

- the fixed multicast control destination;
- the station's own address as source;
- the control type 0x8808;
- the pause opcode 0x0001;
- a 16-bit pause time.

Zero bytes pad the frame out to 60 bytes. The station address and the pause time are captured on the clock edge that starts the frame, so changes to those inputs while the frame is going out do not affect it. Requests that arrive while a frame is pending or in flight merge into one further frame.

Top module: `pause_tx_gen`

## Requirements
- R1: A high level on `req_a_i` or `req_b_i` at a rising edge while `tx_en_i` is high leaves a frame pending. `hold_o` is high in every cycle in which a frame is pending or being sent, and is low otherwise. After reset, `hold_o`, `valid_o`, `sof_o` and `eof_o` are all low.
- R2: A request seen while `tx_en_i` is low is dropped. `tx_en_i` low at an edge also discards a frame that is pending but not yet started. A frame already being sent always completes.
- R3: A pending frame starts at the first rising edge at which `mac_busy_i` is low, `tx_en_i` is high and no frame is being sent. Its first byte appears on `data_o` in the cycle after that edge. No frame starts while `mac_busy_i` is high.
- R4: A frame is exactly 60 consecutive cycles with `valid_o` high. `sof_o` is high on the first of these cycles and `eof_o` on the last.
- R5: Bytes 0 to 5 of the frame are 01 80 C2 00 00 01.
- R6: Bytes 6 to 11 are `station_addr_i`, most significant byte first, as sampled at the start edge.
- R7: Bytes 12 to 15 are 88 08 00 01.
- R8: Bytes 16 and 17 are `pause_time_i`, most significant byte first, as sampled at the start edge. Bytes 18 to 59 are zero.
- R9: Any number of requests made while a frame is pending or being sent cause exactly one more frame. This includes a request at the start edge and one at the edge of the last byte.
- R10: After the last byte of a frame, `valid_o` is low for at least one cycle before another frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_a_i | input | 1 | Pause request strobe, source A |
| req_b_i | input | 1 | Pause request strobe, source B |
| tx_en_i | input | 1 | Transmitter enabled |
| mac_busy_i | input | 1 | Normal transmit path is inside a frame |
| station_addr_i | input | 48 | Station address used as source |
| pause_time_i | input | 16 | Pause time placed in the frame |
| data_o | output | 8 | Frame byte |
| valid_o | output | 1 | `data_o` carries a frame byte |
| sof_o | output | 1 | First byte of the frame |
| eof_o | output | 1 | Last byte of the frame |
| hold_o | output | 1 | Normal path must not start a frame |

## Verification
Two functions can fall on the same clock edge: a new request being latched, and the pending frame being consumed, either at the start edge or at the edge of the final byte. The bench provokes the start case by releasing `mac_busy_i` and pulsing a request in the same cycle. It provokes the end case by pulsing a request exactly in the cycle where `eof_o` is seen. In both cases one extra frame must follow, counted by start strobes, and a behavioural model compares every output against the design on every clock.

// File: rtl/pause_tx_pkg.sv
package pause_tx_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 6;
  localparam int TIME_BYTES = 2;
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int TIME_W     = TIME_BYTES * BYTE_W;
  // dest + src + type + opcode + time
  localparam int HDR_LEN    = 2 * ADDR_BYTES + 4 + TIME_BYTES;
  localparam int HDR_W      = HDR_LEN * BYTE_W;

  localparam logic [ADDR_W-1:0] CTRL_DEST   = 48'h0180_C200_0001;
  localparam logic [15:0]       CTRL_ETYPE  = 16'h8808;
  localparam logic [15:0]       PAUSE_OPC   = 16'h0001;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [TIME_W-1:0] quanta;
  } pause_fields_t;
endpackage

// File: rtl/pause_req_ctrl.sv
module pause_req_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_a_i,
  input  logic req_b_i,
  input  logic tx_en_i,
  input  logic mac_busy_i,
  input  logic sending_i,
  output logic start_o,
  output logic pend_o
);
  logic pend_q, pend_d, req;

  assign req     = req_a_i | req_b_i;
  assign start_o = pend_q & ~sending_i & ~mac_busy_i & tx_en_i;

  always_comb begin
    if (!tx_en_i) pend_d = 1'b0;
    else          pend_d = (pend_q & ~start_o) | req;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_DROP_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> !pend_q); // R2
  AST_REQ_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && (req_a_i || req_b_i)) |=> pend_q); // R1
endmodule

// File: rtl/pause_field_snap.sv
module pause_field_snap
  import pause_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [TIME_W-1:0] quanta_i,
  output pause_fields_t     fields_o
);
  pause_fields_t fields_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fields_q <= '0;
    else if (start_i) fields_q <= '{src: src_i, quanta: quanta_i};
  end

  assign fields_o = fields_q;
endmodule

// File: rtl/pause_frame_seq.sv
module pause_frame_seq #(
  parameter int FRAME_LEN = 60,
  localparam int CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             sending_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             valid_o,
  output logic             sof_o,
  output logic             eof_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic             sending_q;
  logic [CNT_W-1:0] idx_q;
  logic             last;

  assign last = sending_q && (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sending_q <= 1'b0;
      idx_q     <= '0;
    end else if (sending_q) begin
      if (last) begin
        sending_q <= 1'b0;
        idx_q     <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else if (start_i) begin
      sending_q <= 1'b1;
      idx_q     <= '0;
    end
  end

  assign sending_o = sending_q;
  assign idx_o     = idx_q;
  assign valid_o   = sending_q;
  assign sof_o     = sending_q && (idx_q == '0);
  assign eof_o     = last;

  AST_FRAME_CONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !eof_o) |=> (valid_o && !sof_o)); // R4
  AST_SOF_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> $past(!valid_o)); // R4
  AST_GAP_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !valid_o); // R10
endmodule

// File: rtl/pause_byte_gen.sv
module pause_byte_gen
  import pause_tx_pkg::*;
#(
  parameter int FRAME_LEN = 60,
  localparam int CNT_W    = $clog2(FRAME_LEN),
  localparam int HDR_IW   = $clog2(HDR_LEN)
) (
  input  logic [CNT_W-1:0]  idx_i,
  input  pause_fields_t     fields_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [HDR_W-1:0]  hdr;
  logic [BYTE_W-1:0] hdr_bytes [HDR_LEN];

  assign hdr = {CTRL_DEST, fields_i.src, CTRL_ETYPE, PAUSE_OPC, fields_i.quanta};

  for (genvar i = 0; i < HDR_LEN; i++) begin : g_hdr
    assign hdr_bytes[i] = hdr[(HDR_LEN-1-i)*BYTE_W +: BYTE_W];
  end

  // past the header the frame is zero padding
  always_comb begin
    if (idx_i < CNT_W'(HDR_LEN)) byte_o = hdr_bytes[idx_i[HDR_IW-1:0]];
    else                         byte_o = '0;
  end
endmodule

// File: rtl/pause_tx_gen.sv
module pause_tx_gen
  import pause_tx_pkg::*;
#(
  parameter int FRAME_LEN = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_a_i,
  input  logic              req_b_i,
  input  logic              tx_en_i,
  input  logic              mac_busy_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic [TIME_W-1:0] pause_time_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              hold_o
);
  localparam int CNT_W = $clog2(FRAME_LEN);

  logic             start, pend, sending;
  logic [CNT_W-1:0] idx;
  pause_fields_t    fields;

  pause_req_ctrl u_ctrl (
    .clk_i, .rst_ni, .req_a_i, .req_b_i, .tx_en_i, .mac_busy_i,
    .sending_i(sending), .start_o(start), .pend_o(pend)
  );

  pause_field_snap u_snap (
    .clk_i, .rst_ni, .start_i(start),
    .src_i(station_addr_i), .quanta_i(pause_time_i), .fields_o(fields)
  );

  pause_frame_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .sending_o(sending), .idx_o(idx),
    .valid_o, .sof_o, .eof_o
  );

  pause_byte_gen #(.FRAME_LEN(FRAME_LEN)) u_bytes (
    .idx_i(idx), .fields_i(fields), .byte_o(data_o)
  );

  assign hold_o = pend | sending;

  AST_HOLD_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> hold_o); // R1
  AST_START_IN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> $past(!mac_busy_i && tx_en_i)); // R3
endmodule

// File: tb/pause_tx_gen_test.sv
`timescale 1ns/1ps
module pause_tx_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_a = 1'b0, req_b = 1'b0, tx_en = 1'b1, busy = 1'b0;
  logic [47:0] sa = '0;
  logic [15:0] pt = '0;
  logic [7:0]  data;
  logic        valid, sof, eof, hold;

  int n_tests = 0, n_fail = 0, frames = 0;

  always #2.5 clk = ~clk;

  pause_tx_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .req_a_i(req_a), .req_b_i(req_b),
    .tx_en_i(tx_en), .mac_busy_i(busy), .station_addr_i(sa),
    .pause_time_i(pt), .data_o(data), .valid_o(valid), .sof_o(sof),
    .eof_o(eof), .hold_o(hold)
  );

  // behavioural reference
  bit          m_pend, m_send;
  int          m_idx;
  logic [47:0] m_sa;
  logic [15:0] m_pt;

  function automatic logic [7:0] exp_byte(int i, logic [47:0] a, logic [15:0] t);
    logic [7:0] dest [6];
    dest = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01};
    if (i < 6)       return dest[i];
    else if (i < 12) return a[8*(11-i) +: 8];
    else if (i == 12) return 8'h88;
    else if (i == 13) return 8'h08;
    else if (i == 14) return 8'h00;
    else if (i == 15) return 8'h01;
    else if (i == 16) return t[15:8];
    else if (i == 17) return t[7:0];
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_send = 0; m_idx = 0; m_sa = '0; m_pt = '0;
    end else begin
      bit go;
      go = m_pend && !m_send && !busy && tx_en;
      if (m_send) begin
        if (m_idx == 59) begin m_send = 0; m_idx = 0; end
        else m_idx++;
      end else if (go) begin
        m_send = 1; m_idx = 0; m_sa = sa; m_pt = pt;
      end
      if (!tx_en) m_pend = 0;
      else        m_pend = (m_pend && !go) || req_a || req_b;
    end
  end

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 hold", 64'(hold), 64'(m_pend || m_send));
      chk("R4 valid", 64'(valid), 64'(m_send));
      chk("R4 sof", 64'(sof), 64'(m_send && m_idx == 0));
      chk("R4 eof", 64'(eof), 64'(m_send && m_idx == 59));
      if (m_send) begin
        if (m_idx < 6)       chk("R5 dest", 64'(data), 64'(exp_byte(m_idx, m_sa, m_pt)));
        else if (m_idx < 12) chk("R6 src", 64'(data), 64'(exp_byte(m_idx, m_sa, m_pt)));
        else if (m_idx < 16) chk("R7 type/opcode", 64'(data), 64'(exp_byte(m_idx, m_sa, m_pt)));
        else                 chk("R8 time/pad", 64'(data), 64'(exp_byte(m_idx, m_sa, m_pt)));
      end
      if (sof) frames++;
    end
  end

  task automatic pulse(bit a, bit b);
    @(negedge clk); req_a = a; req_b = b;
    @(negedge clk); req_a = 0; req_b = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R4 watchdog: run still active after %0d cycles, expected end", 200000);
    finish_run();
  end

  initial begin
    int f0;
    idle(3);
    chk("R1 reset hold", 64'(hold), 0);
    chk("R1 reset valid", 64'(valid), 0);
    chk("R1 reset sof/eof", 64'({sof, eof}), 0);
    rst_n = 1'b1;

    // basic frame, source changes mid-frame (R6 snapshot)
    sa = 48'h0A1B_2C3D_4E5F; pt = 16'h1234;
    f0 = frames; pulse(1, 0); idle(5);
    sa = 48'hFFEE_DDCC_BBAA; idle(70);
    chk("R1 one frame per request", 64'(frames - f0), 1);

    // wait while normal path busy
    busy = 1; f0 = frames; pulse(0, 1); idle(10);
    chk("R3 no start while busy", 64'(frames - f0), 0);
    busy = 0; idle(70);
    chk("R3 start after busy", 64'(frames - f0), 1);

    // requests during frame collapse
    pt = 16'h0000; f0 = frames; pulse(1, 0); idle(10); pulse(1, 1); idle(3); pulse(0, 1);
    idle(150);
    chk("R9 collapse during frame", 64'(frames - f0), 2);

    // disabled transmitter
    tx_en = 0; f0 = frames; pulse(1, 0); idle(70);
    chk("R2 drop while disabled", 64'(frames - f0), 0);
    tx_en = 1; busy = 1; pulse(1, 0); idle(3); tx_en = 0; idle(2); busy = 0; idle(5);
    tx_en = 1; idle(70);
    chk("R2 pending discarded", 64'(frames - f0), 0);

    // request at the start edge
    pt = 16'hFFFF; sa = 48'hFFFF_FFFF_FFFF;
    busy = 1; f0 = frames; pulse(1, 0); idle(2);
    @(negedge clk); busy = 0; req_a = 1;
    @(negedge clk); req_a = 0;
    idle(150);
    chk("R9 request at start edge", 64'(frames - f0), 2);

    // request at the last-byte edge, then gap (R10)
    f0 = frames; pulse(1, 0);
    @(negedge clk);
    while (!eof) @(negedge clk);
    req_b = 1;
    @(negedge clk); req_b = 0;
    chk("R10 gap after eof", 64'(valid), 0);
    idle(70);
    chk("R9 request at eof edge", 64'(frames - f0), 2);

    idle(5);
    finish_run();
  end
endmodule